// File: doc/BRIEF.md
# Register-Configured IO Pad Multiplexer

This block sits between a row of pad-side IO cells and a set of peripheral functions. Each cell owns a small select register. The select value decides which peripheral function drives the pad's output value. The same value also picks the pad's output-enable, so changing the selection moves the direction control together with the data. The pad's input value travels back only to the selected function.

Software sets the select registers through a plain address/data port. The cell index is a fixed bit slice of the address. A request to an index with no cell behind it is refused and flagged, both for reads and for writes. Each cell has 2^SEL_W mux legs. Only the lowest NUM_WIRED legs carry a peripheral function. A select value that points at an unwired leg drives zero on the pad output and on the output-enable, which leaves the pad tri-stated. The select width may be as small as one bit, which gives a 2-way mux.

Top module: `iomux_top`

## Requirements
- R1: After reset every select register holds 0. rd_err, wr_err and rdata read 0 on the first cycle after reset is released.
- R2: A write with wr_en=1 to a valid index stores wdata[SEL_W-1:0] into that cell's select register at the next clock edge. Higher data bits are dropped. On the cycle after the request, wr_err is 0.
- R3: A write to an index of NUM_CELLS or more changes no select register. On the cycle after the request, wr_err is 1.
- R4: A read with rd_en=1 from a valid index returns that cell's select value, zero-extended to DATA_W, on rdata on the cycle after the request, with rd_err 0. A read issued in the same cycle as a write returns the value held before the write.
- R5: A read from an index of NUM_CELLS or more returns rdata 0 and rd_err 1 on the cycle after the request.
- R6: The cell index is addr[IDX_HI:IDX_LO], and index k addresses cell k. All other address bits have no effect.
- R7: For each cell c with select value s < NUM_WIRED, the pad signals are driven combinationally from leg s: pad_out[c] = fn_out[c*2^SEL_W+s] and pad_oe[c] = fn_oe[c*2^SEL_W+s].
- R8: For each cell c with select value s < NUM_WIRED, fn_in[c*2^SEL_W+s] equals pad_in[c], and every other leg of that cell's fn_in is 0.
- R9: A select value of NUM_WIRED or more drives pad_out[c]=0 and pad_oe[c]=0, and drives every fn_in leg of that cell to 0.
- R10: With SEL_W=1, each cell acts as a 2-way mux that follows R2, R4, R7 and R8.
- R11: A cycle without wr_en leaves wr_err 0 on the next cycle. A cycle without rd_en leaves rd_err 0 and rdata 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | ADDR_W | Request address; the cell index is bits IDX_HI..IDX_LO |
| wdata | input | DATA_W | Write data; the low SEL_W bits are stored |
| wr_err | output | 1 | Registered: previous write hit no cell |
| rdata | output | DATA_W | Registered read data |
| rd_err | output | 1 | Registered: previous read hit no cell |
| fn_out | input | NUM_CELLS*2^SEL_W | Output value from each peripheral function, leg l of cell c at bit c*2^SEL_W+l |
| fn_oe | input | NUM_CELLS*2^SEL_W | Output-enable from each peripheral function, same layout |
| fn_in | output | NUM_CELLS*2^SEL_W | Pad input value delivered to each function, same layout |
| pad_in | input | NUM_CELLS | Input value from each IO cell |
| pad_out | output | NUM_CELLS | Output value to each IO cell |
| pad_oe | output | NUM_CELLS | Output-enable to each IO cell |

## Verification
On every cycle, the assertions check these properties:
- An unwired select leaves its pad tri-stated and low.
- At most one function leg per cell sees the pad input, and that leg carries the pad value when the selection is wired.
- A refused write raises wr_err and leaves every select register unchanged.
- A refused read raises rd_err with zero data.
- Idle cycles produce no error flags.

Only the bench's scenarios can show the rest:
- The correct leg is picked for each select value.
- Stored values are truncated.
- Address bits outside the slice are ignored.
- A read in the same cycle as a write returns the old value.
- The 1-bit select configuration behaves correctly.

For these, the bench sweeps every cell through every select value against its own model.

// File: rtl/iomux_pkg.sv
package iomux_pkg;

  // Number of mux legs per cell for a given select width.
  function automatic int unsigned leg_count(input int unsigned sel_w);
    return 32'd1 << sel_w;
  endfunction

  // True when a decoded index addresses an existing cell.
  function automatic logic index_valid(input int unsigned idx, input int unsigned cells);
    return idx < cells;
  endfunction

endpackage

// File: rtl/iomux_regbank.sv
module iomux_regbank import iomux_pkg::*; #(
  parameter int unsigned NUM_CELLS = 4,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [SEL_W-1:0]           wsel,
  output logic                       wr_err,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rd_err,
  output logic [NUM_CELLS*SEL_W-1:0] sel_flat
);

  logic             idx_ok;
  logic [SEL_W-1:0] rd_val;

  assign idx_ok = index_valid(32'(idx), NUM_CELLS);

  // One select register per cell.
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_flat[c*SEL_W +: SEL_W] <= '0;
      end else if (wr_en && idx_ok && (32'(idx) == c)) begin
        sel_flat[c*SEL_W +: SEL_W] <= wsel;
      end
    end
  end

  // Read selection, kept in range by the loop bound.
  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NUM_CELLS; c++) begin
      if (32'(idx) == c) rd_val = sel_flat[c*SEL_W +: SEL_W];
    end
  end

  // Registered responses.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rd_err <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      rdata  <= (rd_en && idx_ok) ? DATA_W'(rd_val) : '0;
      rd_err <= rd_en && !idx_ok;
      wr_err <= wr_en && !idx_ok;
    end
  end

endmodule

// File: rtl/iomux_cell.sv
module iomux_cell #(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned NUM_WIRED = 3,
  localparam int unsigned LEGS     = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [LEGS-1:0]  fn_out,
  input  logic [LEGS-1:0]  fn_oe,
  input  logic             pad_in,
  output logic             pad_out,
  output logic             pad_oe,
  output logic [LEGS-1:0]  fn_in
);

  localparam int unsigned WIRED = (NUM_WIRED < LEGS) ? NUM_WIRED : LEGS;

  // Unwired legs contribute constant zero in both directions.
  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    fn_in   = '0;
    for (int l = 0; l < WIRED; l++) begin
      if (32'(sel) == l) begin
        pad_out  = fn_out[l];
        pad_oe   = fn_oe[l];
        fn_in[l] = pad_in;
      end
    end
  end

endmodule

// File: rtl/iomux_top.sv
module iomux_top import iomux_pkg::*; #(
  parameter int unsigned NUM_CELLS = 4,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned NUM_WIRED = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_LO    = 2,
  parameter int unsigned IDX_HI    = 5
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wdata,
  output logic                                wr_err,
  output logic [DATA_W-1:0]                   rdata,
  output logic                                rd_err,
  input  logic [NUM_CELLS*(1<<SEL_W)-1:0]     fn_out,
  input  logic [NUM_CELLS*(1<<SEL_W)-1:0]     fn_oe,
  output logic [NUM_CELLS*(1<<SEL_W)-1:0]     fn_in,
  input  logic [NUM_CELLS-1:0]                pad_in,
  output logic [NUM_CELLS-1:0]                pad_out,
  output logic [NUM_CELLS-1:0]                pad_oe
);

  localparam int unsigned LEGS  = leg_count(SEL_W);
  localparam int unsigned IDX_W = IDX_HI - IDX_LO + 1;

  logic [IDX_W-1:0]           idx;
  logic [NUM_CELLS*SEL_W-1:0] sel_flat;
  logic                       unused_req_bits;

  assign idx             = addr[IDX_HI:IDX_LO];
  assign unused_req_bits = ^{addr, wdata};

  iomux_regbank #(
    .NUM_CELLS(NUM_CELLS),
    .SEL_W    (SEL_W),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .idx     (idx),
    .wsel    (wdata[SEL_W-1:0]),
    .wr_err  (wr_err),
    .rdata   (rdata),
    .rd_err  (rd_err),
    .sel_flat(sel_flat)
  );

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    iomux_cell #(
      .SEL_W    (SEL_W),
      .NUM_WIRED(NUM_WIRED)
    ) u_cell (
      .sel    (sel_flat[c*SEL_W +: SEL_W]),
      .fn_out (fn_out[c*LEGS +: LEGS]),
      .fn_oe  (fn_oe[c*LEGS +: LEGS]),
      .pad_in (pad_in[c]),
      .pad_out(pad_out[c]),
      .pad_oe (pad_oe[c]),
      .fn_in  (fn_in[c*LEGS +: LEGS])
    );
  end

endmodule

// File: rtl/iomux_chk.sv
module iomux_chk #(
  parameter int unsigned NUM_CELLS = 4,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned NUM_WIRED = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_LO    = 2,
  parameter int unsigned IDX_HI    = 5,
  localparam int unsigned LEGS     = 1 << SEL_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [ADDR_W-1:0]          addr,
  input logic                       wr_err,
  input logic [DATA_W-1:0]          rdata,
  input logic                       rd_err,
  input logic [NUM_CELLS*LEGS-1:0]  fn_in,
  input logic [NUM_CELLS-1:0]       pad_in,
  input logic [NUM_CELLS-1:0]       pad_out,
  input logic [NUM_CELLS-1:0]       pad_oe,
  input logic [NUM_CELLS*SEL_W-1:0] sel_flat
);

  logic bad_idx;
  assign bad_idx = 32'(addr[IDX_HI:IDX_LO]) >= NUM_CELLS;

  // R3
  bad_write_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bad_idx) |=> wr_err);

  // R3
  bad_write_keeps_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bad_idx) |=> $stable(sel_flat));

  // R5
  bad_read_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bad_idx) |=> (rd_err && rdata == '0));

  // R11
  idle_no_error_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !rd_en) |=> (!wr_err && !rd_err && rdata == '0));

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell_chk
    // R9
    unwired_tristate_chk: assert property (@(posedge clk) disable iff (rst)
      (32'(sel_flat[c*SEL_W +: SEL_W]) >= NUM_WIRED)
        |-> (!pad_out[c] && !pad_oe[c] && fn_in[c*LEGS +: LEGS] == '0));

    // R8
    single_input_leg_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(fn_in[c*LEGS +: LEGS]));

    // R8
    input_reaches_leg_chk: assert property (@(posedge clk) disable iff (rst)
      (32'(sel_flat[c*SEL_W +: SEL_W]) < NUM_WIRED)
        |-> ((|fn_in[c*LEGS +: LEGS]) == pad_in[c]));
  end

endmodule

bind iomux_top iomux_chk #(
  .NUM_CELLS(NUM_CELLS),
  .SEL_W    (SEL_W),
  .NUM_WIRED(NUM_WIRED),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .IDX_LO   (IDX_LO),
  .IDX_HI   (IDX_HI)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_err  (wr_err),
  .rdata   (rdata),
  .rd_err  (rd_err),
  .fn_in   (fn_in),
  .pad_in  (pad_in),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .sel_flat(sel_flat)
);

// File: tb/iomux_top_bench.sv
module iomux_top_bench;

  localparam int NC = 4, SW = 2, LG = 4, NW = 3, AW = 8, DW = 32;
  localparam int NC1 = 2, SW1 = 1, LG1 = 2, NW1 = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // main configuration
  logic          wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr_err, rd_err;
  logic [DW-1:0] rdata;
  logic [NC*LG-1:0] fn_out = '0, fn_oe = '0, fn_in;
  logic [NC-1:0]    pad_in = '0, pad_out, pad_oe;

  // narrow (1-bit select) configuration
  logic          n_wr_en = 0, n_rd_en = 0;
  logic [AW-1:0] n_addr = '0;
  logic [DW-1:0] n_wdata = '0;
  logic          n_wr_err, n_rd_err;
  logic [DW-1:0] n_rdata;
  logic [NC1*LG1-1:0] n_fn_out = '0, n_fn_oe = '0, n_fn_in;
  logic [NC1-1:0]     n_pad_in = '0, n_pad_out, n_pad_oe;

  int n_chk = 0, n_fail = 0;
  int unsigned model [NC];
  bit done = 0;

  iomux_top #(.NUM_CELLS(NC), .SEL_W(SW), .NUM_WIRED(NW), .ADDR_W(AW), .DATA_W(DW),
              .IDX_LO(2), .IDX_HI(5)) u_iomux_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .wr_err(wr_err), .rdata(rdata), .rd_err(rd_err), .fn_out(fn_out), .fn_oe(fn_oe),
    .fn_in(fn_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  iomux_top #(.NUM_CELLS(NC1), .SEL_W(SW1), .NUM_WIRED(NW1), .ADDR_W(AW), .DATA_W(DW),
              .IDX_LO(2), .IDX_HI(5)) u_iomux_top_w1 (
    .clk(clk), .rst(rst), .wr_en(n_wr_en), .rd_en(n_rd_en), .addr(n_addr), .wdata(n_wdata),
    .wr_err(n_wr_err), .rdata(n_rdata), .rd_err(n_rd_err), .fn_out(n_fn_out), .fn_oe(n_fn_oe),
    .fn_in(n_fn_in), .pad_in(n_pad_in), .pad_out(n_pad_out), .pad_oe(n_pad_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit exp_err, input string req);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    chk({req, " wr_err"}, 32'(wr_err), 32'(exp_err));
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp_d, input bit exp_err, input string req);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    chk({req, " rdata"}, rdata, exp_d);
    chk({req, " rd_err"}, 32'(rd_err), 32'(exp_err));
  endtask

  // Compare pads and function inputs of one cell against the model (R7 R8 R9).
  task automatic route_chk(input int c);
    logic [15:0] pats [4] = '{16'hA5C3, 16'h5A3C, 16'hFFFF, 16'h0000};
    int s = int'(model[c]);
    for (int p = 0; p < 4; p++) begin
      for (int pi = 0; pi < 2; pi++) begin
        fn_out = pats[p];
        fn_oe  = {pats[p][7:0], ~pats[p][15:8]};
        pad_in = pi[0] ? 4'hF : 4'h0;
        #1;
        if (s < NW) begin
          chk("R7 pad_out", 32'(pad_out[c]), 32'(fn_out[c*LG+s]));
          chk("R7 pad_oe", 32'(pad_oe[c]), 32'(fn_oe[c*LG+s]));
          chk("R8 fn_in", 32'(fn_in[c*LG +: LG]), pi[0] ? (32'd1 << s) : 32'd0);
        end else begin
          chk("R9 pad_out", 32'(pad_out[c]), 0);
          chk("R9 pad_oe", 32'(pad_oe[c]), 0);
          chk("R9 fn_in", 32'(fn_in[c*LG +: LG]), 0);
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) model[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state; R11 idle cycle
    chk("R1 wr_err", 32'(wr_err), 0);
    chk("R1 rd_err", 32'(rd_err), 0);
    chk("R11 rdata idle", rdata, 0);
    for (int c = 0; c < NC; c++) rd(AW'(c << 2), 0, 0, "R1 reset select");
    for (int c = 0; c < NC; c++) route_chk(c);

    // R2 R4 R7 R8 R9: sweep every select value on every cell
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < LG; s++) begin
        wr(AW'(c << 2), DW'(s), 0, "R2 write");
        model[c] = s;
        rd(AW'(c << 2), DW'(s), 0, "R4 readback");
        route_chk(c);
      end
    end

    // R2 truncation of wide data
    wr(AW'(1 << 2), 32'hFFFF_FFF5, 0, "R2 truncate");
    model[1] = 1;
    rd(AW'(1 << 2), 1, 0, "R2 truncated value");

    // R6 bits outside the index slice ignored
    wr(8'hC3 | AW'(2 << 2), 32'h2, 0, "R6 write");
    model[2] = 2;
    rd(8'h43 | AW'(2 << 2), 2, 0, "R6 read");
    route_chk(2);

    // R3 R5 out-of-range indices
    for (int k = NC; k < 16; k++) begin
      wr(AW'(k << 2), 32'h3, 1, "R3 bad write");
      rd(AW'(k << 2), 0, 1, "R5 bad read");
    end
    for (int c = 0; c < NC; c++) rd(AW'(c << 2), DW'(model[c]), 0, "R3 selects kept");

    // R4 read and write in one cycle returns the old value
    @(negedge clk);
    wr_en = 1; rd_en = 1; addr = AW'(3 << 2); wdata = 32'h1;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R4 same-cycle old value", rdata, DW'(model[3]));
    model[3] = 1;
    @(negedge clk);
    chk("R11 idle wr_err", 32'(wr_err), 0);
    chk("R11 idle rd_err", 32'(rd_err), 0);
    rd(AW'(3 << 2), 1, 0, "R4 after same-cycle write");

    // R10 one-bit select configuration
    for (int c = 0; c < NC1; c++) begin
      for (int s = 0; s < LG1; s++) begin
        @(negedge clk);
        n_wr_en = 1; n_addr = AW'(c << 2); n_wdata = 32'hFFFF_FFFE | DW'(s);
        @(negedge clk);
        n_wr_en = 0; n_rd_en = 1;
        chk("R10 wr_err", 32'(n_wr_err), 0);
        @(negedge clk);
        n_rd_en = 0;
        chk("R10 readback", n_rdata, DW'(s));
        for (int p = 0; p < 4; p++) begin
          n_fn_out = 4'(p * 5 + 3);
          n_fn_oe  = 4'(p * 3 + 6);
          n_pad_in = p[0] ? 2'b11 : 2'b00;
          #1;
          chk("R10 pad_out", 32'(n_pad_out[c]), 32'(n_fn_out[c*LG1+s]));
          chk("R10 pad_oe", 32'(n_pad_oe[c]), 32'(n_fn_oe[c*LG1+s]));
          chk("R10 fn_in", 32'(n_fn_in[c*LG1 +: LG1]), p[0] ? (32'd1 << s) : 32'd0);
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule